// File: doc/BRIEF.md
# Quad Down-Counting Interval Timer

This peripheral holds four independent decrementing counters behind one synchronous register port. Each counter can be armed with a start value, slowed by a selectable clock divider, and run in one of three ways. In free-running mode it rolls over to all ones. In periodic mode it restarts from a stored reload value. In single-shot mode it stops when it expires. A counter can run as a full 32-bit counter or be narrowed to its low half.

Each counter keeps a reload value apart from its live count. Software can stage a new period that is picked up only at the next rollover, which leaves the count in progress alone. Expiry events from all four counters gather in a common interrupt section. That section has a per-counter enable mask, a raw status view, a masked status view and a write-one-to-clear port, and it drives one combined interrupt line. Register reads are combinational while the port is selected. Writes take effect at the next clock edge.

Top module: `qdt_timer_top`

## Requirements
- R1: After reset every control register and the interrupt mask read zero, raw status reads zero, and the load and count storage of every counter hold all ones. Because control resets to half-width mode, the count reads 0x0000FFFF until the width bit is set, and then it reads 0xFFFFFFFF.
- R2: Byte offsets 0x00, 0x04, 0x08 and 0x0C are the interrupt mask, raw status, masked status and clear registers, with bit n belonging to counter n. Counter n owns offsets 0x10+0x10*n: +0x0 start value, +0x4 live count (read-only), +0x8 control, +0xC staged reload. Control reads back as written in bits 7, 6, 3:2, 1 and 0.
- R3: A write to the start value loads the live count and the reload value at once. While control bit 7 is set, the count drops by one on every divided tick, starting at the first edge after the enabling write. While bit 7 is clear, the count holds.
- R4: Control bits 3:2 choose the divider: 00 gives one tick per clock, 01 one per 16 clocks, and 10 or 11 one per 256 clocks.
- R5: The tick that takes the count from 1 to 0 sets raw status bit n at the same edge.
- R6: With bits 6 and 0 clear, the tick that finds the count at zero sets it to all ones of the active width.
- R7: With bit 6 set and bit 0 clear, the tick that finds the count at zero loads the reload value.
- R8: A write to the staged reload register changes only the reload value. The live count keeps decrementing undisturbed. The start-value offset reads back the current reload value.
- R9: With bit 0 set, the counter stops at zero and clears bit 7 when it expires. This holds even if bit 6 is also set.
- R10: With bit 1 clear, only the low 16 bits count, and the upper 16 bits of the count read as zero.
- R11: Writing 1 to a clear-register bit clears that raw status bit. Writing 0 leaves it unchanged.
- R12: Masked status equals raw status AND mask, and the interrupt output is high exactly when any masked bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common register and counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while selected |
| irq_o | output | 1 | Combined interrupt |

## Verification
A table of stimulus rows arms one counter at a time with differing start values, divider codes, widths and modes. After a chosen wait it reads the live count. The expected value, start minus the whole ticks elapsed, separates the three divider codes from one another and half-width arithmetic from full-width arithmetic. Directed sequences then walk each counter across zero in free-running, periodic, single-shot and half-width modes. These show what follows expiry in each mode: rollover value, reload value, or holding with the enable dropped. Further sequences stage a new reload during a run, mask and clear the interrupt, and idle a disabled counter. Together they separate the live count from the reload value, and the raw status from the masked status and the interrupt line.

// File: rtl/qdt_pkg.sv
`timescale 1ns/1ps
package qdt_pkg;

    localparam int DATA_W = 32;
    localparam int PRE_W  = 8;

    // control bit positions seen by software
    localparam int CB_RUN      = 7;
    localparam int CB_PERIODIC = 6;
    localparam int CB_DIV_HI   = 3;
    localparam int CB_DIV_LO   = 2;
    localparam int CB_WIDE     = 1;
    localparam int CB_SINGLE   = 0;

    // word index inside a register group (address bits 3:2)
    localparam logic [1:0] W_MASK  = 2'd0;
    localparam logic [1:0] W_RAW   = 2'd1;
    localparam logic [1:0] W_MIS   = 2'd2;
    localparam logic [1:0] W_CLR   = 2'd3;
    localparam logic [1:0] W_START = 2'd0;
    localparam logic [1:0] W_COUNT = 2'd1;
    localparam logic [1:0] W_CTRL  = 2'd2;
    localparam logic [1:0] W_STAGE = 2'd3;

    typedef enum logic [1:0] {
        DIV_1     = 2'b00,
        DIV_16    = 2'b01,
        DIV_256   = 2'b10,
        DIV_256_B = 2'b11
    } div_sel_e;

    typedef struct packed {
        logic     run;
        logic     periodic;
        div_sel_e div;
        logic     wide;
        logic     single;
    } ctrl_t;

    function automatic ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.run      = w[CB_RUN];
        c.periodic = w[CB_PERIODIC];
        c.div      = div_sel_e'(w[CB_DIV_HI:CB_DIV_LO]);
        c.wide     = w[CB_WIDE];
        c.single   = w[CB_SINGLE];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w                     = '0;
        w[CB_RUN]             = c.run;
        w[CB_PERIODIC]        = c.periodic;
        w[CB_DIV_HI:CB_DIV_LO] = c.div;
        w[CB_WIDE]            = c.wide;
        w[CB_SINGLE]          = c.single;
        return w;
    endfunction

endpackage

// File: rtl/qdt_prescale.sv
`timescale 1ns/1ps
module qdt_prescale
    import qdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  logic     restart,
    input  div_sel_e div,
    output logic     tick
);

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        case (div)
            DIV_1:   limit = '0;
            DIV_16:  limit = PRE_W'(15);
            default: limit = PRE_W'(255);
        endcase
        tick = run && !restart && (st_q.phase == limit);
        st_d = st_q;
        if (!run || restart || tick) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/qdt_channel.sv
`timescale 1ns/1ps
module qdt_channel
    import qdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic              wr_ctrl,
    input  logic              wr_stage,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt_view,
    output logic [CNT_W-1:0]  rld_view,
    output ctrl_t             ctrl_q,
    output logic              evt
);

    localparam int HALF_W = CNT_W / 2;
    localparam logic [CNT_W-1:0] LOW_MASK = {{(CNT_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        ctrl_t            ctrl;
    } chan_st_t;

    chan_st_t         st_d, st_q;
    logic             tick;
    logic [CNT_W-1:0] width_mask;
    logic [CNT_W-1:0] cur;
    logic [CNT_W-1:0] rel;

    qdt_prescale u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.ctrl.run),
        .restart (wr_start),
        .div     (st_q.ctrl.div),
        .tick    (tick)
    );

    always_comb begin
        width_mask = st_q.ctrl.wide ? {CNT_W{1'b1}} : LOW_MASK;
        cur        = st_q.cnt & width_mask;
        rel        = st_q.rld & width_mask;
        st_d       = st_q;
        evt        = 1'b0;

        if (tick && !wr_start) begin
            if (cur == '0) begin
                if (st_q.ctrl.single) begin
                    evt          = 1'b1;
                    st_d.ctrl.run = 1'b0;
                end else if (st_q.ctrl.periodic) begin
                    st_d.cnt = rel;
                end else begin
                    st_d.cnt = width_mask;
                end
            end else begin
                st_d.cnt = cur - 1'b1;
                if (cur == CNT_W'(1)) begin
                    evt = 1'b1;
                    if (st_q.ctrl.single) begin
                        st_d.ctrl.run = 1'b0;
                    end
                end
            end
        end

        if (wr_ctrl) begin
            st_d.ctrl = word_to_ctrl(wdata);
        end
        if (wr_stage) begin
            st_d.rld = CNT_W'(wdata);
        end
        if (wr_start) begin
            st_d.cnt = CNT_W'(wdata);
            st_d.rld = CNT_W'(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= '1;
            st_q.rld  <= '1;
            st_q.ctrl <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_view = st_q.cnt & width_mask;
    assign rld_view = st_q.rld & width_mask;
    assign ctrl_q   = st_q.ctrl;

endmodule

// File: rtl/qdt_irq.sv
`timescale 1ns/1ps
module qdt_irq #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mask,
    input  logic              wr_clr,
    input  logic [NUM_CH-1:0] wbits,
    input  logic [NUM_CH-1:0] evt,
    output logic [NUM_CH-1:0] mask_q,
    output logic [NUM_CH-1:0] raw_q,
    output logic [NUM_CH-1:0] mis,
    output logic              irq
);

    typedef struct packed {
        logic [NUM_CH-1:0] mask;
        logic [NUM_CH-1:0] raw;
    } irq_st_t;

    irq_st_t           st_d, st_q;
    logic [NUM_CH-1:0] clr_bits;

    always_comb begin
        st_d     = st_q;
        clr_bits = wr_clr ? wbits : '0;
        if (wr_mask) begin
            st_d.mask = wbits;
        end
        st_d.raw = (st_q.raw & ~clr_bits) | evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q = st_q.mask;
    assign raw_q  = st_q.raw;
    assign mis    = st_q.raw & st_q.mask;
    assign irq    = |mis;

endmodule

// File: rtl/qdt_timer_top.sv
`timescale 1ns/1ps
module qdt_timer_top
    import qdt_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);

    localparam int GRP_W = ADDR_W - 4;

    logic [GRP_W-1:0]             grp;
    logic [1:0]                   word;
    logic                         wr_any;
    logic                         shared_hit;
    logic                         wr_mask;
    logic                         wr_clr;
    logic [NUM_CH-1:0]            ch_hit;
    logic [NUM_CH-1:0]            ld_wr;
    logic [NUM_CH-1:0]            ctl_wr;
    logic [NUM_CH-1:0]            bg_wr;
    logic [NUM_CH-1:0]            ch_evt;
    logic [NUM_CH-1:0]            ch_run;
    logic [NUM_CH-1:0]            ch_single;
    logic [NUM_CH-1:0]            clr_bits;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_view;
    logic [NUM_CH-1:0][CNT_W-1:0] rld_view;
    ctrl_t                        ch_ctrl [NUM_CH];
    logic [NUM_CH-1:0]            mask_q;
    logic [NUM_CH-1:0]            raw_q;
    logic [NUM_CH-1:0]            mis;
    logic                         unused_addr_lsb;

    assign grp             = bus_addr[ADDR_W-1:4];
    assign word            = bus_addr[3:2];
    assign unused_addr_lsb = ^bus_addr[1:0];
    assign wr_any          = bus_sel && bus_wr;
    assign shared_hit      = (grp == '0);
    assign wr_mask         = wr_any && shared_hit && (word == W_MASK);
    assign wr_clr          = wr_any && shared_hit && (word == W_CLR);
    assign clr_bits        = wr_clr ? bus_wdata[NUM_CH-1:0] : '0;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ctrl_t ctl;

        assign ch_hit[i] = (grp == GRP_W'(i + 1));
        assign ld_wr[i]  = wr_any && ch_hit[i] && (word == W_START);
        assign ctl_wr[i] = wr_any && ch_hit[i] && (word == W_CTRL);
        assign bg_wr[i]  = wr_any && ch_hit[i] && (word == W_STAGE);

        qdt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_start (ld_wr[i]),
            .wr_ctrl  (ctl_wr[i]),
            .wr_stage (bg_wr[i]),
            .wdata    (bus_wdata),
            .cnt_view (cnt_view[i]),
            .rld_view (rld_view[i]),
            .ctrl_q   (ctl),
            .evt      (ch_evt[i])
        );

        assign ch_ctrl[i]   = ctl;
        assign ch_run[i]    = ctl.run;
        assign ch_single[i] = ctl.single;
    end

    qdt_irq #(.NUM_CH(NUM_CH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (wr_mask),
        .wr_clr  (wr_clr),
        .wbits   (bus_wdata[NUM_CH-1:0]),
        .evt     (ch_evt),
        .mask_q  (mask_q),
        .raw_q   (raw_q),
        .mis     (mis),
        .irq     (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            if (shared_hit) begin
                case (word)
                    W_MASK:  bus_rdata = DATA_W'(mask_q);
                    W_RAW:   bus_rdata = DATA_W'(raw_q);
                    W_MIS:   bus_rdata = DATA_W'(mis);
                    default: bus_rdata = '0;
                endcase
            end
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_hit[i]) begin
                    case (word)
                        W_START: bus_rdata = DATA_W'(rld_view[i]);
                        W_COUNT: bus_rdata = DATA_W'(cnt_view[i]);
                        W_CTRL:  bus_rdata = ctrl_to_word(ch_ctrl[i]);
                        default: bus_rdata = DATA_W'(rld_view[i]);
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/qdt_timer_chk.sv
`timescale 1ns/1ps
module qdt_timer_chk #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CH-1:0]            ch_run,
    input logic [NUM_CH-1:0]            ch_single,
    input logic [NUM_CH-1:0]            ld_wr,
    input logic [NUM_CH-1:0]            ctl_wr,
    input logic [NUM_CH-1:0]            ch_evt,
    input logic [NUM_CH-1:0]            clr_bits,
    input logic [NUM_CH-1:0]            mask_q,
    input logic [NUM_CH-1:0]            raw_q,
    input logic                         irq_o,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_view
);

    // R11: a raw bit only falls when the clear port named it
    p_raw_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((~raw_q & $past(raw_q) & ~$past(clr_bits)) == '0));

    // R12: nothing enabled in the mask keeps the line low
    p_mask_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R3: a stopped counter with no write holds its count
        p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_run[i] && !ld_wr[i] && !ctl_wr[i]) |=> $stable(cnt_view[i]));

        // R5: an expiry latches raw status at the same edge
        p_evt_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ch_evt[i] |=> raw_q[i]);

        // R5: an expiry leaves the count at zero
        p_evt_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ch_evt[i] |=> (cnt_view[i] == '0));

        // R9: a single-shot expiry drops the enable
        p_single_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_evt[i] && ch_single[i] && !ctl_wr[i]) |=> !ch_run[i]);
    end

endmodule

bind qdt_timer_top qdt_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_run    (ch_run),
    .ch_single (ch_single),
    .ld_wr     (ld_wr),
    .ctl_wr    (ctl_wr),
    .ch_evt    (ch_evt),
    .clr_bits  (clr_bits),
    .mask_q    (mask_q),
    .raw_q     (raw_q),
    .irq_o     (irq_o),
    .cnt_view  (cnt_view)
);

// File: tb/qdt_timer_top_bench.sv
`timescale 1ns/1ps
module qdt_timer_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    qdt_timer_top u_qdt_timer_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    typedef struct packed {
        logic [1:0]  ch;
        logic [7:0]  ctl;
        logic [31:0] ld;
        logic [15:0] wt;
        logic [31:0] ex;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'h82, 32'd1000,       16'd10,  32'd990},
        '{2'd1, 8'h86, 32'd500,        16'd40,  32'd498},
        '{2'd2, 8'h8A, 32'h0001_0000,  16'd300, 32'h0000_FFFF},
        '{2'd3, 8'h80, 32'hABCD_0040,  16'd5,   32'h0000_003B},
        '{2'd0, 8'hC2, 32'd50,         16'd20,  32'd30},
        '{2'd1, 8'h83, 32'd100,        16'd7,   32'd93},
        '{2'd2, 8'h86, 32'd3,          16'd15,  32'd3}
    };

    function automatic logic [7:0] ch_addr(input int ch, input int w);
        return 8'(16 * (ch + 1) + 4 * w);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel  = 1'b1;
        bus_wr   = 1'b0;
        bus_addr = a;
        #1;
        d       = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        logic [31:0] d;
        string       tag;

        wait_edges(4);
        rst_n = 1'b1;
        wait_edges(1);

        // R1: reset state
        rd(8'h00, d); chk("R1 mask", d, 32'h0);
        rd(8'h04, d); chk("R1 raw", d, 32'h0);
        rd(8'h08, d); chk("R1 masked", d, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        rd(ch_addr(0, 2), d); chk("R1 ctrl", d, 32'h0);
        rd(ch_addr(0, 1), d); chk("R1 count half", d, 32'h0000_FFFF);
        wr(ch_addr(0, 2), 32'h02);
        rd(ch_addr(0, 1), d); chk("R1 count wide", d, 32'hFFFF_FFFF);
        rd(ch_addr(0, 0), d); chk("R1 load wide", d, 32'hFFFF_FFFF);

        // table of arming vectors
        for (int i = 0; i < NV; i++) begin
            wr(ch_addr(int'(VECS[i].ch), 2), 32'h0);
            wr(ch_addr(int'(VECS[i].ch), 0), VECS[i].ld);
            wr(ch_addr(int'(VECS[i].ch), 2), {24'h0, VECS[i].ctl});
            wait_edges(int'(VECS[i].wt));
            rd(ch_addr(int'(VECS[i].ch), 1), d);
            if (VECS[i].ctl[3:2] != 2'b00) tag = "R4 divider";
            else if (!VECS[i].ctl[1]) tag = "R10 half width";
            else tag = "R3 decrement";
            chk(tag, d, VECS[i].ex);
        end

        // quiesce all counters, clear status
        for (int c = 0; c < 4; c++) wr(ch_addr(c, 2), 32'h0);
        wr(8'h0C, 32'hF);
        rd(8'h04, d); chk("R11 clear all", d, 32'h0);

        // R2: control and mask readback
        wr(ch_addr(1, 2), 32'h46);
        rd(ch_addr(1, 2), d); chk("R2 ctrl readback", d, 32'h46);
        wr(8'h00, 32'h5);
        rd(8'h00, d); chk("R2 mask readback", d, 32'h5);
        wr(8'h00, 32'h0);
        wr(ch_addr(1, 2), 32'h0);

        // free-running expiry, status and interrupt
        wr(ch_addr(0, 0), 32'd5);
        wr(ch_addr(0, 2), 32'h82);
        wait_edges(4);
        rd(ch_addr(0, 1), d); chk("R3 count before zero", d, 32'd1);
        rd(8'h04, d); chk("R5 raw before zero", d, 32'h0);
        wait_edges(1);
        rd(ch_addr(0, 1), d); chk("R3 count at zero", d, 32'd0);
        rd(8'h04, d); chk("R5 raw set", d, 32'h1);
        rd(8'h08, d); chk("R12 masked off", d, 32'h0);
        chk("R12 irq masked", {31'b0, irq_o}, 32'h0);
        wait_edges(1);
        rd(ch_addr(0, 1), d); chk("R6 wrap", d, 32'hFFFF_FFFF);
        wr(8'h00, 32'h1);
        rd(8'h08, d); chk("R12 masked on", d, 32'h1);
        chk("R12 irq on", {31'b0, irq_o}, 32'h1);
        wr(8'h0C, 32'h0);
        rd(8'h04, d); chk("R11 zero write", d, 32'h1);
        wr(8'h0C, 32'h1);
        rd(8'h04, d); chk("R11 one write", d, 32'h0);
        chk("R12 irq cleared", {31'b0, irq_o}, 32'h0);
        wr(ch_addr(0, 2), 32'h0);
        wr(8'h00, 32'h0);

        // periodic reload with staged value
        wr(ch_addr(1, 0), 32'd4);
        wr(ch_addr(1, 2), 32'hC2);
        wait_edges(4);
        rd(ch_addr(1, 1), d); chk("R7 zero", d, 32'd0);
        wait_edges(1);
        rd(ch_addr(1, 1), d); chk("R7 reload", d, 32'd4);
        wr(ch_addr(1, 3), 32'd9);
        rd(ch_addr(1, 1), d); chk("R8 count undisturbed", d, 32'd3);
        rd(ch_addr(1, 0), d); chk("R8 load reads reload", d, 32'd9);
        wait_edges(3);
        rd(ch_addr(1, 1), d); chk("R7 zero again", d, 32'd0);
        wait_edges(1);
        rd(ch_addr(1, 1), d); chk("R8 staged reload used", d, 32'd9);
        wr(ch_addr(1, 2), 32'h0);

        // single shot, periodic bit also set
        wr(8'h0C, 32'hF);
        wr(ch_addr(2, 0), 32'd3);
        wr(ch_addr(2, 2), 32'hC3);
        wait_edges(3);
        rd(ch_addr(2, 1), d); chk("R9 at zero", d, 32'd0);
        rd(8'h04, d); chk("R5 single raw", d, 32'h4);
        rd(ch_addr(2, 2), d); chk("R9 enable dropped", d, 32'h43);
        wait_edges(5);
        rd(ch_addr(2, 1), d); chk("R9 holds zero", d, 32'd0);

        // half width
        wr(8'h0C, 32'hF);
        wr(ch_addr(3, 0), 32'hFFFF_0002);
        rd(ch_addr(3, 1), d); chk("R10 upper reads zero", d, 32'h0000_0002);
        wr(ch_addr(3, 2), 32'h80);
        wait_edges(2);
        rd(ch_addr(3, 1), d); chk("R10 zero", d, 32'h0);
        rd(8'h04, d); chk("R5 half raw", d, 32'h8);
        wait_edges(1);
        rd(ch_addr(3, 1), d); chk("R10 half wrap", d, 32'h0000_FFFF);
        wr(ch_addr(3, 2), 32'h0);

        // disabled counter holds
        wr(ch_addr(0, 0), 32'd77);
        wait_edges(20);
        rd(ch_addr(0, 1), d); chk("R3 disabled hold", d, 32'd77);

        summary();
    end

endmodule